// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block holds the five status flags of an asynchronous serial port: transmit buffer empty, receive buffer full, receive overrun, parity error and framing error. Hardware events from the transmit and receive datapaths set the flags. Two agents can clear them. The CPU clears a flag with a two-step handshake: it reads the status word while the flag is 1, then writes a 0 to that flag's bit. A transfer engine clears a flag as a side effect when it accesses the matching data buffer. Writing 1 never sets a flag.

Each flag remembers on its own whether the CPU has seen it at 1. That "armed" mark is removed by any status write, and also when the flag drops to 0 by any other path. A hardware set that arrives in the same cycle as a clear always wins, so no event is lost. Standby entry forces the flags back to their reset values, exactly as reset does. Two interrupt requests are formed from the buffer flags and their enables. A parameter chooses whether those requests come from a register or directly from logic.

Top module: `serial_status_flags`

## Requirements
- R1: After reset, and in the cycle after any cycle with `standby` high, `stat_rd` equals 5'b10000: the transmit-empty flag is 1 and every other flag is 0. `standby` overrides every other input.
- R2: A status write with a 1 in a flag's bit never sets that flag, and neither does a write of 0. Bit layout of `stat_rd` and `stat_wdata`: [4] transmit empty, [3] receive full, [2] overrun, [1] framing error, [0] parity error.
- R3: A status write with 0 in a flag's bit clears that flag only when a status read (`cpu_rd`) has returned the flag as 1 since the last status write, and the flag has stayed 1 since that read.
- R4: Any status write removes the armed mark of every flag, whatever the written value. A later write of 0 then clears nothing until the flag is read as 1 again.
- R5: While `tx_en` is 0, the transmit-empty flag is 1 in the following cycle.
- R6: `tx_moved` (buffer moved into the shift register) sets transmit empty. `dma_tx_wr` (transfer engine writes the transmit buffer) clears it.
- R7: `rx_done` (error-free reception delivered to the buffer) sets receive full. `dma_rx_rd` (transfer engine reads the receive buffer) clears it.
- R8: `ovr_evt`, `frm_evt` and `par_evt` each set their own error flag. Only the CPU handshake clears these flags.
- R9: If a set event for a flag and a clear of that flag (handshake or transfer engine) occur in the same cycle, the flag is 1 afterwards.
- R10: With IRQ_REG=1, `irq_tx` equals the previous cycle's (transmit empty AND `tx_irq_en`), and `irq_rx` equals the previous cycle's (receive full AND `rx_irq_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby entry; forces reset flag values |
| cpu_rd | input | 1 | CPU reads the status word this cycle |
| cpu_wr | input | 1 | CPU writes the status word this cycle |
| stat_wdata | input | 5 | Status write data |
| stat_rd | output | 5 | Current status word |
| tx_en | input | 1 | Transmitter enable |
| tx_moved | input | 1 | Transmit buffer moved into the shift register |
| dma_tx_wr | input | 1 | Transfer engine writes the transmit buffer |
| rx_done | input | 1 | Error-free reception delivered to the buffer |
| dma_rx_rd | input | 1 | Transfer engine reads the receive buffer |
| ovr_evt | input | 1 | Receive overrun detected |
| frm_evt | input | 1 | Framing error detected |
| par_evt | input | 1 | Parity error detected |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
The assertions check, on every cycle, the behaviours that depend only on the current inputs. These are the standby values, the forcing of transmit empty while the transmitter is off, set-wins on receive full, the transfer-engine clear of receive full, the absence of spontaneous sets, the rule that an error flag can only fall after a write or standby, and the one-cycle timing of the interrupt requests. The read-then-write handshake depends on history, so only the bench's scenarios can show it. Those scenarios cover a write without a prior read, a write after a read, and disarming by an intervening write. They also cover a read that races with a clear, and randomly mixed traffic, all compared against a cycle-level reference model.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
   localparam int unsigned NFLAG = 5;
   localparam int unsigned B_PAR = 0;
   localparam int unsigned B_FRM = 1;
   localparam int unsigned B_OVR = 2;
   localparam int unsigned B_RXF = 3;
   localparam int unsigned B_TXE = 4;
   localparam logic [NFLAG-1:0] RST_PATTERN = 5'b10000;
endpackage

// File: rtl/ssf_flag_cell.sv
module ssf_flag_cell #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic force_rst,
   input  logic set_evt,
   input  logic hw_clr,
   input  logic sw_rd,
   input  logic sw_wr,
   input  logic sw_bit,
   output logic flag_q
);
   logic armed_q;
   logic flag_d;
   logic armed_d;
   logic sw_clr;

   // software clear only when armed and a zero is written
   assign sw_clr = sw_wr && !sw_bit && armed_q;

   always_comb begin
      if (force_rst)                flag_d = RST_VAL;
      else if (set_evt)             flag_d = 1'b1;
      else if (hw_clr || sw_clr)    flag_d = 1'b0;
      else                          flag_d = flag_q;
   end

   // armed survives only while the flag stays 1 and no write occurs
   assign armed_d = !force_rst && !sw_wr && flag_d && (armed_q || (sw_rd && flag_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= RST_VAL;
         armed_q <= 1'b0;
      end else begin
         flag_q  <= flag_d;
         armed_q <= armed_d;
      end
   end
endmodule

// File: rtl/ssf_irq_stage.sv
module ssf_irq_stage #(
   parameter int unsigned NREQ    = 2,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] src,
   input  logic [NREQ-1:0] ena,
   output logic [NREQ-1:0] req
);
   logic [NREQ-1:0] raw;
   assign raw = src & ena;

   generate
      if (IRQ_REG) begin : g_reg
         logic [NREQ-1:0] req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= '0;
            else        req_q <= raw;
         end
         assign req = req_q;
      end else begin : g_comb
         assign req = raw;
         // clock and reset are unused in this variant
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
      end
   endgenerate
endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags
   import ssf_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             standby,
   input  logic             cpu_rd,
   input  logic             cpu_wr,
   input  logic [NFLAG-1:0] stat_wdata,
   output logic [NFLAG-1:0] stat_rd,
   input  logic             tx_en,
   input  logic             tx_moved,
   input  logic             dma_tx_wr,
   input  logic             rx_done,
   input  logic             dma_rx_rd,
   input  logic             ovr_evt,
   input  logic             frm_evt,
   input  logic             par_evt,
   input  logic             tx_irq_en,
   input  logic             rx_irq_en,
   output logic             irq_tx,
   output logic             irq_rx
);
   localparam int unsigned NREQ = 2;

   initial begin
      if (NFLAG != 5) $error("serial_status_flags: flag count must be 5");
      if (RST_PATTERN != 5'b10000) $error("serial_status_flags: unexpected reset pattern");
   end

   logic [NFLAG-1:0] set_vec;
   logic [NFLAG-1:0] clr_vec;
   logic [NFLAG-1:0] flags;

   always_comb begin
      set_vec        = '0;
      clr_vec        = '0;
      set_vec[B_TXE] = tx_moved || !tx_en;
      clr_vec[B_TXE] = dma_tx_wr;
      set_vec[B_RXF] = rx_done;
      clr_vec[B_RXF] = dma_rx_rd;
      set_vec[B_OVR] = ovr_evt;
      set_vec[B_FRM] = frm_evt;
      set_vec[B_PAR] = par_evt;
   end

   generate
      for (genvar g = 0; g < NFLAG; g++) begin : g_flag
         ssf_flag_cell #(.RST_VAL(RST_PATTERN[g])) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .force_rst (standby),
            .set_evt   (set_vec[g]),
            .hw_clr    (clr_vec[g]),
            .sw_rd     (cpu_rd),
            .sw_wr     (cpu_wr),
            .sw_bit    (stat_wdata[g]),
            .flag_q    (flags[g])
         );
      end
   endgenerate

   assign stat_rd = flags;

   logic [NREQ-1:0] req;
   ssf_irq_stage #(.NREQ(NREQ), .IRQ_REG(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .src   ({flags[B_RXF], flags[B_TXE]}),
      .ena   ({rx_irq_en, tx_irq_en}),
      .req   (req)
   );
   assign irq_tx = req[0];
   assign irq_rx = req[1];
endmodule

// File: rtl/ssf_checker.sv
module ssf_checker
   import ssf_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             standby,
   input logic             cpu_wr,
   input logic [NFLAG-1:0] stat_rd,
   input logic             tx_en,
   input logic             rx_done,
   input logic             dma_rx_rd,
   input logic             ovr_evt,
   input logic             tx_irq_en,
   input logic             rx_irq_en,
   input logic             irq_tx,
   input logic             irq_rx
);
   a_r1_standby_values: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> (stat_rd == 5'b10000));

   a_r5_txoff_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby && !tx_en) |=> stat_rd[B_TXE]);

   a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby && rx_done) |=> stat_rd[B_RXF]);

   a_r7_dma_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby && dma_rx_rd && !rx_done) |=> !stat_rd[B_RXF]);

   a_r2_no_set_without_event: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby && !ovr_evt && !stat_rd[B_OVR]) |=> !stat_rd[B_OVR]);

   a_r3_error_falls_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_rd[B_PAR]) |-> ($past(cpu_wr) || $past(standby)));

   generate
      if (IRQ_REG) begin : g_irq_chk
         a_r10_irq_tx_timing: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_tx == $past(stat_rd[B_TXE] && tx_irq_en)));
         a_r10_irq_rx_timing: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_rx == $past(stat_rd[B_RXF] && rx_irq_en)));
      end
   endgenerate
endmodule

bind serial_status_flags ssf_checker #(.IRQ_REG(IRQ_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .standby   (standby),
   .cpu_wr    (cpu_wr),
   .stat_rd   (stat_rd),
   .tx_en     (tx_en),
   .rx_done   (rx_done),
   .dma_rx_rd (dma_rx_rd),
   .ovr_evt   (ovr_evt),
   .tx_irq_en (tx_irq_en),
   .rx_irq_en (rx_irq_en),
   .irq_tx    (irq_tx),
   .irq_rx    (irq_rx)
);

// File: tb/sim_serial_status_flags.sv
`timescale 1ns/1ps
module sim_serial_status_flags;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic standby = 0, cpu_rd = 0, cpu_wr = 0;
   logic [4:0] stat_wdata = '0;
   logic [4:0] stat_rd;
   logic tx_en = 1, tx_moved = 0, dma_tx_wr = 0, rx_done = 0, dma_rx_rd = 0;
   logic ovr_evt = 0, frm_evt = 0, par_evt = 0, tx_irq_en = 0, rx_irq_en = 0;
   logic irq_tx, irq_rx;

   always #2.5 clk = ~clk;

   serial_status_flags #(.IRQ_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .standby(standby), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .stat_wdata(stat_wdata), .stat_rd(stat_rd), .tx_en(tx_en), .tx_moved(tx_moved),
      .dma_tx_wr(dma_tx_wr), .rx_done(rx_done), .dma_rx_rd(dma_rx_rd), .ovr_evt(ovr_evt),
      .frm_evt(frm_evt), .par_evt(par_evt), .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
      .irq_tx(irq_tx), .irq_rx(irq_rx));

   // reference model: bit order [4]=tx empty,[3]=rx full,[2]=overrun,[1]=framing,[0]=parity
   bit m_flag [5];
   bit m_seen [5];
   bit m_irq_tx, m_irq_rx;
   int errors = 0, checks = 0;
   string cur_req = "R1";
   bit done = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_flag[i]) begin m_flag[i] = (i == 4); m_seen[i] = 0; end
         m_irq_tx = 0; m_irq_rx = 0;
      end else begin
         bit ev_set [5];
         bit ev_clr [5];
         bit prev;
         m_irq_tx = m_flag[4] & tx_irq_en;
         m_irq_rx = m_flag[3] & rx_irq_en;
         ev_set[4] = tx_moved | ~tx_en;  ev_clr[4] = dma_tx_wr;
         ev_set[3] = rx_done;            ev_clr[3] = dma_rx_rd;
         ev_set[2] = ovr_evt;            ev_clr[2] = 0;
         ev_set[1] = frm_evt;            ev_clr[1] = 0;
         ev_set[0] = par_evt;            ev_clr[0] = 0;
         for (int i = 0; i < 5; i++) begin
            prev = m_flag[i];
            if (standby) begin
               m_flag[i] = (i == 4);
               m_seen[i] = 0;
            end else begin
               if (ev_set[i]) m_flag[i] = 1;
               else if (ev_clr[i] || (cpu_wr && !stat_wdata[i] && m_seen[i])) m_flag[i] = 0;
               if (cpu_wr || !m_flag[i]) m_seen[i] = 0;
               else if (cpu_rd && prev) m_seen[i] = 1;
            end
         end
      end
   end

   function automatic logic [4:0] model_word();
      logic [4:0] w;
      for (int i = 0; i < 5; i++) w[i] = m_flag[i];
      return w;
   endfunction

   task automatic compare();
      checks++;
      if (stat_rd !== model_word() || irq_tx !== m_irq_tx || irq_rx !== m_irq_rx) begin
         errors++;
         $display("FAIL %s: got stat=%b irq_tx=%b irq_rx=%b, expected stat=%b irq_tx=%b irq_rx=%b",
                  cur_req, stat_rd, irq_tx, irq_rx, model_word(), m_irq_tx, m_irq_rx);
      end
   endtask

   task automatic idle_inputs();
      standby = 0; cpu_rd = 0; cpu_wr = 0; stat_wdata = '0;
      tx_moved = 0; dma_tx_wr = 0; rx_done = 0; dma_rx_rd = 0;
      ovr_evt = 0; frm_evt = 0; par_evt = 0;
   endtask

   // one clock: inputs set by caller, then compare at the next falling edge
   task automatic step();
      @(negedge clk);
      compare();
      idle_inputs();
   endtask

   task automatic expect_word(input logic [4:0] exp, input string tag);
      checks++;
      if (stat_rd !== exp) begin
         errors++;
         $display("FAIL %s: got stat=%b expected %b", tag, stat_rd, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_word(5'b10000, "R1 reset");
      rst_n = 1;
      step();

      // R5: transmitter off keeps tx empty set even against a DMA write (R9)
      cur_req = "R5";
      tx_en = 0; dma_tx_wr = 1; step();
      expect_word(5'b10000, "R5 tx off");
      tx_en = 1; step();

      // R6: DMA write clears, move sets
      cur_req = "R6";
      dma_tx_wr = 1; step();
      expect_word(5'b00000, "R6 dma clear");
      // R2: writing ones sets nothing
      cur_req = "R2";
      cpu_wr = 1; stat_wdata = 5'b11111; step();
      expect_word(5'b00000, "R2 write ones");
      cur_req = "R6";
      tx_moved = 1; step();
      expect_word(5'b10000, "R6 move sets");

      // R8: error events
      cur_req = "R8";
      ovr_evt = 1; step();
      frm_evt = 1; step();
      par_evt = 1; step();
      expect_word(5'b10111, "R8 errors set");

      // R3: write zero without read does nothing
      cur_req = "R3";
      cpu_wr = 1; stat_wdata = 5'b00000; step();
      expect_word(5'b10111, "R3 unarmed write");
      cpu_rd = 1; step();
      cpu_wr = 1; stat_wdata = 5'b11011; step();
      expect_word(5'b10011, "R3 armed clear overrun");

      // R4: an intervening write disarms
      cur_req = "R4";
      cpu_rd = 1; step();
      cpu_wr = 1; stat_wdata = 5'b11111; step();
      cpu_wr = 1; stat_wdata = 5'b11100; step();
      expect_word(5'b10011, "R4 disarmed");

      // R9: handshake clear and parity event together
      cur_req = "R9";
      cpu_rd = 1; step();
      cpu_wr = 1; stat_wdata = 5'b11100; par_evt = 1; step();
      expect_word(5'b10001, "R9 set wins");

      // R7: receive full set and DMA clear, with set winning
      cur_req = "R7";
      rx_done = 1; step();
      expect_word(5'b11001, "R7 rx set");
      rx_done = 1; dma_rx_rd = 1; step();
      expect_word(5'b11001, "R7 set wins over dma");
      dma_rx_rd = 1; step();
      expect_word(5'b10001, "R7 dma clear");

      // R10: interrupt timing
      cur_req = "R10";
      tx_irq_en = 1; rx_irq_en = 1; rx_done = 1; step();
      step(); step();
      dma_tx_wr = 1; dma_rx_rd = 1; step();
      step();

      // R1: standby mid-run
      cur_req = "R1";
      rx_done = 1; ovr_evt = 1; step();
      standby = 1; rx_done = 1; step();
      expect_word(5'b10000, "R1 standby");
      // armed state lost through standby
      cpu_rd = 1; step();
      standby = 1; step();
      cpu_wr = 1; stat_wdata = 5'b00000; step();
      expect_word(5'b10000, "R1 standby disarms");

      // mixed random traffic against the model
      cur_req = "R10 mixed";
      for (int n = 0; n < 2000; n++) begin
         logic [15:0] r;
         r = 16'($urandom);
         cpu_rd = r[0]; cpu_wr = r[1] & r[2]; stat_wdata = 5'($urandom);
         tx_en = |r[4:3]; tx_moved = r[5] & r[6]; dma_tx_wr = r[7];
         rx_done = r[8] & r[9]; dma_rx_rd = r[10]; ovr_evt = r[11] & r[12] & r[0];
         frm_evt = r[12] & r[13] & r[1]; par_evt = r[13] & r[14] & r[2];
         tx_irq_en = r[14]; rx_irq_en = r[15];
         standby = (r[15:10] == 6'h3f);
         step();
      end
      finish_up();
   end
endmodule